// File: doc/BRIEF.md
# Banked Address Decoder

This block turns a 16-bit processor address into one chip select and one local offset for each target in the memory map. The targets are an 8K work RAM, an 8K I/O register space, an 8K video RAM and a 64K cartridge ROM. The upper half of the address space is split into two 16K cartridge windows. The lower of the two windows is switchable: a bank field taken from the system-control register chooses which 16K of the cartridge appears there. The upper window is fixed to the last 16K of the cartridge.

The decoder is purely combinational and sits between the processor bus and the memories. A select is asserted only while a read or write strobe is active. The 8K region at 0x6000–0x7FFF is unmapped. A read there raises an open-bus indication and a fill byte of 0xFF. A write there asserts nothing, so it is dropped.

Top module: `banked_addr_decoder`

## Requirements
- R1: With a strobe active and an address in 0x0000–0x1FFF, only `wram_cs` is high and `wram_addr` equals address bits [12:0].
- R2: With a strobe active and an address in 0x2000–0x3FFF, only `io_cs` is high and `io_addr` equals address bits [12:0].
- R3: With a strobe active and an address in 0x4000–0x5FFF, only `vram_cs` is high and `vram_addr` equals the low 13 address bits.
- R4: A read of 0x6000–0x7FFF asserts no select, drives `open_bus` high and drives `fill_data` to 0xFF.
- R5: A write to 0x6000–0x7FFF asserts no select and leaves `open_bus` low and `fill_data` at 0x00.
- R6: With a strobe active and an address in 0x8000–0xBFFF, only `cart_cs` is high and `cart_addr` = (address mod 0x4000) + bank × 0x4000. Bank 0 gives the first 16K, bank 1 the second and bank 2 the third.
- R7: Only bank field bits [1:0] are used. Bit 2 has no effect on `cart_addr`, and bank value 3 maps the switchable window onto the last 16K.
- R8: With a strobe active and an address in 0xC000–0xFFFF, `cart_cs` is high and `cart_addr` = (address mod 0x4000) + 0xC000, whatever the bank field holds.
- R9: With neither strobe active, every select and `open_bus` are low. Every offset output of a deasserted select reads 0, and no more than one select is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 16 | Processor address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| bank_sel | input | 3 | Bank field from the system-control register |
| wram_cs | output | 1 | Work RAM select |
| wram_addr | output | 13 | Work RAM offset |
| io_cs | output | 1 | I/O register space select |
| io_addr | output | 13 | I/O register offset |
| vram_cs | output | 1 | Video RAM select |
| vram_addr | output | 13 | Video RAM offset |
| cart_cs | output | 1 | Cartridge ROM select |
| cart_addr | output | 16 | Cartridge offset in the 64K space |
| open_bus | output | 1 | Read of the unmapped region |
| fill_data | output | 8 | 0xFF during an open-bus read, else 0x00 |

## Verification
In one cycle, the bank field can change while an access lands in one of the two cartridge windows. A switched-window access must follow the new bank at once. A fixed-window access must not react to the bank at all. The bench changes `bank_sel` on every cycle of a long pseudo-random run, drives directed accesses at every region boundary under all eight bank values, and compares each output with a behavioural reference model that uses integer division and modulo.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  typedef enum logic [2:0] {
    RGN_WRAM   = 3'd0,
    RGN_IO     = 3'd1,
    RGN_VRAM   = 3'd2,
    RGN_NONE   = 3'd3,
    RGN_CART_S = 3'd4,
    RGN_CART_F = 3'd5
  } region_e;
endpackage

// File: rtl/bdec_region.sv
module bdec_region
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (addr[TOP -: 3])
      3'd0:          region = RGN_WRAM;
      3'd1:          region = RGN_IO;
      3'd2:          region = RGN_VRAM;
      3'd3:          region = RGN_NONE;
      3'd4, 3'd5:    region = RGN_CART_S;
      default:       region = RGN_CART_F;
    endcase
  end
endmodule

// File: rtl/bdec_cart_map.sv
module bdec_cart_map
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CART_W = 16,
  parameter int BANK_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  region_e           region,
  output logic [CART_W-1:0] cart_off
);
  localparam int WIN_W = ADDR_W - 2;
  localparam int PG_W  = CART_W - WIN_W;

  logic [PG_W-1:0] bank_pg;
  logic [PG_W-1:0] page;

  generate
    if (BANK_W >= PG_W) begin : g_slice
      assign bank_pg = bank[PG_W-1:0];
    end else begin : g_extend
      assign bank_pg = {{(PG_W-BANK_W){1'b0}}, bank};
    end
  endgenerate

  always_comb begin
    page = (region == RGN_CART_F) ? {PG_W{1'b1}} : bank_pg;
    cart_off = {page, addr[WIN_W-1:0]};
  end
endmodule

// File: rtl/bdec_select.sv
module bdec_select
  import bdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  region_e           region,
  input  logic              rd,
  input  logic              wr,
  output logic              wram_sel,
  output logic              io_sel,
  output logic              vram_sel,
  output logic              cart_sel,
  output logic              hole_rd,
  output logic [DATA_W-1:0] fill
);
  logic access;

  always_comb begin
    access   = rd | wr;
    wram_sel = access && (region == RGN_WRAM);
    io_sel   = access && (region == RGN_IO);
    vram_sel = access && (region == RGN_VRAM);
    cart_sel = access && ((region == RGN_CART_S) || (region == RGN_CART_F));
    hole_rd  = rd && (region == RGN_NONE);
    fill     = hole_rd ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  end
endmodule

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CART_W = 16,
  parameter int BANK_W = 3,
  parameter int DATA_W = 8,
  localparam int OFF_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              wram_cs,
  output logic [OFF_W-1:0]  wram_addr,
  output logic              io_cs,
  output logic [OFF_W-1:0]  io_addr,
  output logic              vram_cs,
  output logic [OFF_W-1:0]  vram_addr,
  output logic              cart_cs,
  output logic [CART_W-1:0] cart_addr,
  output logic              open_bus,
  output logic [DATA_W-1:0] fill_data
);
  region_e           region;
  logic [CART_W-1:0] cart_off;

  bdec_region #(.ADDR_W(ADDR_W)) u_region (
    .addr   (cpu_addr),
    .region (region)
  );

  bdec_cart_map #(.ADDR_W(ADDR_W), .CART_W(CART_W), .BANK_W(BANK_W)) u_cart (
    .addr     (cpu_addr),
    .bank     (bank_sel),
    .region   (region),
    .cart_off (cart_off)
  );

  bdec_select #(.DATA_W(DATA_W)) u_sel (
    .region   (region),
    .rd       (rd_en),
    .wr       (wr_en),
    .wram_sel (wram_cs),
    .io_sel   (io_cs),
    .vram_sel (vram_cs),
    .cart_sel (cart_cs),
    .hole_rd  (open_bus),
    .fill     (fill_data)
  );

  always_comb begin
    wram_addr = wram_cs ? cpu_addr[OFF_W-1:0] : '0;
    io_addr   = io_cs   ? cpu_addr[OFF_W-1:0] : '0;
    vram_addr = vram_cs ? cpu_addr[OFF_W-1:0] : '0;
    cart_addr = cart_cs ? cart_off : '0;
  end
endmodule

// File: rtl/banked_addr_decoder_chk.sv
module banked_addr_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int CART_W = 16,
  parameter int DATA_W = 8
) (
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic              wram_cs,
  input logic              io_cs,
  input logic              vram_cs,
  input logic              cart_cs,
  input logic [CART_W-1:0] cart_addr,
  input logic              open_bus,
  input logic [DATA_W-1:0] fill_data
);
  localparam int WIN_W = ADDR_W - 2;

  always_comb begin
    // R9
    one_select_chk: assert ($onehot0({wram_cs, io_cs, vram_cs, cart_cs, open_bus}));
    // R9
    idle_quiet_chk: assert ((rd_en | wr_en) || !(wram_cs | io_cs | vram_cs | cart_cs | open_bus));
    // R4
    open_fill_chk: assert (!open_bus || (fill_data == {DATA_W{1'b1}}));
    // R5
    hole_write_chk: assert (!(wr_en && !rd_en) || !open_bus);
    // R8
    fixed_page_chk: assert (!(cart_cs && (cpu_addr[ADDR_W-1 -: 2] == 2'b11)) ||
                            (cart_addr[CART_W-1 -: 2] == 2'b11));
    // R6
    cart_low_chk: assert (!cart_cs || (cart_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]));
  end
endmodule

bind banked_addr_decoder banked_addr_decoder_chk #(
  .ADDR_W(ADDR_W), .CART_W(CART_W), .DATA_W(DATA_W)
) u_chk (
  .cpu_addr  (cpu_addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wram_cs   (wram_cs),
  .io_cs     (io_cs),
  .vram_cs   (vram_cs),
  .cart_cs   (cart_cs),
  .cart_addr (cart_addr),
  .open_bus  (open_bus),
  .fill_data (fill_data)
);

// File: tb/tb_banked_addr_decoder.sv
module tb_banked_addr_decoder;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        rd_en, wr_en;
  logic [2:0]  bank_sel;
  logic        wram_cs, io_cs, vram_cs, cart_cs, open_bus;
  logic [12:0] wram_addr, io_addr, vram_addr;
  logic [15:0] cart_addr;
  logic [7:0]  fill_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  banked_addr_decoder dut (
    .cpu_addr(cpu_addr), .rd_en(rd_en), .wr_en(wr_en), .bank_sel(bank_sel),
    .wram_cs(wram_cs), .wram_addr(wram_addr), .io_cs(io_cs), .io_addr(io_addr),
    .vram_cs(vram_cs), .vram_addr(vram_addr), .cart_cs(cart_cs),
    .cart_addr(cart_addr), .open_bus(open_bus), .fill_data(fill_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: integer arithmetic on the memory map
  function automatic logic [84:0] model(input int a, input bit rd, input bit wr,
                                        input int bank, output string tag);
    int seg, wa, ia, va, ca, fd;
    bit w, i, v, c, ob;
    {w, i, v, c, ob} = '0;
    wa = 0; ia = 0; va = 0; ca = 0; fd = 0;
    seg = a / 8192;
    tag = "R9";
    if (rd || wr) begin
      case (seg)
        0: begin w = 1; wa = a % 8192; tag = "R1"; end
        1: begin i = 1; ia = a % 8192; tag = "R2"; end
        2: begin v = 1; va = a % 8192; tag = "R3"; end
        3: begin
          if (rd) begin ob = 1; fd = 255; tag = "R4"; end
          else tag = "R5";
        end
        4, 5: begin
          c = 1;
          ca = (a % 16384) + (bank % 4) * 16384;
          tag = (bank >= 3) ? "R7" : "R6";
        end
        default: begin c = 1; ca = (a % 16384) + 49152; tag = "R8"; end
      endcase
    end
    model = {w, wa[12:0], i, ia[12:0], v, va[12:0], c, ca[15:0], ob, fd[7:0]};
    model[84:79] = '0;
    model[78:0]  = {w, wa[12:0], i, ia[12:0], v, va[12:0], c, ca[15:0], ob, fd[7:0]};
  endfunction

  task automatic check_now(input string why);
    logic [84:0] exp_v, act_v;
    string tag;
    exp_v = model(int'(cpu_addr), rd_en, wr_en, int'(bank_sel), tag);
    act_v = {6'd0, wram_cs, wram_addr, io_cs, io_addr, vram_cs, vram_addr,
             cart_cs, cart_addr, open_bus, fill_data};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s (%s) addr=%h rd=%0b wr=%0b bank=%0d actual=%h expected=%h",
               tag, why, cpu_addr, rd_en, wr_en, bank_sel, act_v, exp_v);
    end
  endtask

  task automatic drive(input logic [15:0] a, input bit rd, input bit wr,
                       input logic [2:0] b, input string why);
    @(posedge clk);
    #1;
    cpu_addr = a; rd_en = rd; wr_en = wr; bank_sel = b;
    @(negedge clk);
    check_now(why);
  endtask

  initial begin
    logic [15:0] edges [12];
    logic [31:0] lfsr;
    edges = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'h5FFF,
              16'h6000, 16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
    cpu_addr = 16'h0000; rd_en = 0; wr_en = 0; bank_sel = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("reset state, R9 idle");
    rst_n = 1'b1;

    // R9: idle strobes across every region
    for (int k = 0; k < 12; k++) drive(edges[k], 0, 0, 3'd5, "R9 no strobe");

    // boundaries under every bank value, read and write (R1..R8)
    for (int b = 0; b < 8; b++)
      for (int k = 0; k < 12; k++) begin
        drive(edges[k], 1, 0, 3'(b), "boundary read");
        drive(edges[k], 0, 1, 3'(b), "boundary write");
      end

    // R7: bank bit 2 ignored, same address with bank 1 and 5
    drive(16'h9234, 1, 0, 3'd1, "R7 bank 1");
    drive(16'h9234, 1, 0, 3'd5, "R7 bank 5 aliases bank 1");
    // R8: bank changes while accessing the fixed window
    for (int b = 0; b < 8; b++) drive(16'hD00D, 1, 0, 3'(b), "R8 bank switch under fixed window");

    // pseudo-random sweep, bank changes every cycle
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[15:0], lfsr[16], lfsr[17], lfsr[20:18], "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired (R9 run incomplete) actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule